// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block keeps the fetch address for a 12-bit-instruction microcontroller core. Each cycle in which the instruction strobe is high, it looks at the instruction that has just arrived from program memory and chooses the next fetch address. Straight-line code advances the address by one. An unconditional jump or a subroutine call forms its target from a short literal in the instruction, placed under a 3-bit page register. A return takes its address from a two-entry return stack. One return variant also puts the page register back to the value it held at the call. A page-select instruction loads the page register directly.

Fetch runs one slot ahead of execute. So any change of flow, and any conditional skip reported by the execute unit, leaves one fetched word that must not run. A two-state controller tracks this. In `ST_RUN` the arriving instruction is acted on. In `ST_SLOT_ANNUL` it is discarded and runs as a no-op. The transitions are:
- `ST_RUN` to `ST_SLOT_ANNUL` on a taken jump, call, return or skip.
- `ST_SLOT_ANNUL` to `ST_RUN` on the next valid slot.
- Either state holds while the strobe is low.

The literal-returning return also asks the datapath to load its 8-bit literal into the working register.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `fetch_addr` is 0xFFF, `page_bits` is 0 and `flush_slot` is 0.
- R2: A valid, non-annulled instruction that is not a flow change and has no skip request advances `fetch_addr` by one, wrapping from 0xFFF to 0x000, and leaves `flush_slot` at 0.
- R3: A jump (bits [11:9] = 101) sets `fetch_addr` to {page_bits, instr[8:0]} and raises `flush_slot`.
- R4: A call (bits [11:8] = 1001) pushes the current `fetch_addr` together with `page_bits`, sets `fetch_addr` to {page_bits, 0, instr[7:0]} and raises `flush_slot`.
- R5: The plain return (0x00C) pops the stack, loads the popped address into `fetch_addr`, leaves `page_bits` unchanged, does not assert `w_load` and raises `flush_slot`.
- R6: The literal return (bits [11:8] = 1000) behaves as R5. In addition, during its slot it asserts `w_load` with `w_literal` = instr[7:0].
- R7: The page-restoring return (0x00D) behaves as R5 and also loads `page_bits` from the popped entry.
- R8: Page select (bits [11:3] = 0000_0001_0) loads instr[2:0] into `page_bits` and advances `fetch_addr` by one.
- R9: `skip_req` high with a valid, non-annulled, non-flow-change instruction advances `fetch_addr` by one and raises `flush_slot`.
- R10: A valid instruction arriving while `flush_slot` is 1 has no effect. It causes no jump, push, pop, page change or skip, and no `w_load`. `fetch_addr` advances by one and `flush_slot` clears.
- R11: While `instr_valid` is low, `fetch_addr`, `page_bits` and `flush_slot` hold.
- R12: The stack holds two entries. A third push drops the oldest entry. A pop from a stack holding a single entry leaves that bottom entry in place, so the next pop returns it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 12 | Instruction word entering execute |
| skip_req | input | 1 | Execute unit reports a taken conditional skip |
| fetch_addr | output | 12 | Program memory fetch address |
| flush_slot | output | 1 | Next valid slot is annulled (no-op) |
| w_load | output | 1 | Load `w_literal` into the working register this cycle |
| w_literal | output | 8 | Literal carried by the literal return |
| page_bits | output | 3 | Current page-select register |

## Verification
The hardest case to reach is the stack edge behaviour. The bench must overflow the stack and then pop past its bottom, and every call and return along the way also generates an annulled slot that must be stepped over. The stimulus nests three calls, each followed by a dummy slot. It then issues three plain returns. The last return must repeat the middle call's return address, and the first caller's address must never reappear. A separate sequence changes the page between a call and its return. This shows that only the page-restoring return brings the old page back.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int DEF_PC_W  = 12;
    localparam int DEF_PG_W  = 3;
    localparam int DEF_DEPTH = 2;
    localparam int INSTR_W   = 12;
    localparam int LIT8_W    = 8;

    typedef enum logic [0:0] {
        ST_RUN       = 1'b0,
        ST_SLOT_ANNUL = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        OPC_OTHER = 3'd0,
        OPC_JUMP  = 3'd1,
        OPC_CALL  = 3'd2,
        OPC_RET   = 3'd3,
        OPC_RETL  = 3'd4,
        OPC_RETPG = 3'd5,
        OPC_PAGE  = 3'd6
    } op_class_e;

endpackage

// File: rtl/pc_seq_decode.sv
module pc_seq_decode
    import pc_seq_pkg::*;
#(
    parameter int PC_W = DEF_PC_W,
    parameter int PG_W = DEF_PG_W
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [PG_W-1:0]    page,
    output op_class_e          op,
    output logic [PC_W-1:0]    jump_tgt,
    output logic [PC_W-1:0]    call_tgt,
    output logic [PG_W-1:0]    page_lit,
    output logic [LIT8_W-1:0]  lit8
);
    localparam int LIT_W   = PC_W - PG_W;
    localparam int CPAD_W  = LIT_W - LIT8_W;

    always_comb begin
        op = OPC_OTHER;
        if (instr[11:9] == 3'b101)
            op = OPC_JUMP;
        else if (instr[11:8] == 4'b1001)
            op = OPC_CALL;
        else if (instr[11:8] == 4'b1000)
            op = OPC_RETL;
        else if (instr == 12'h00C)
            op = OPC_RET;
        else if (instr == 12'h00D)
            op = OPC_RETPG;
        else if (instr[11:3] == 9'b0000_0001_0)
            op = OPC_PAGE;
    end

    assign jump_tgt = {page, instr[LIT_W-1:0]};
    assign call_tgt = {page, {CPAD_W{1'b0}}, instr[LIT8_W-1:0]};
    assign page_lit = instr[PG_W-1:0];
    assign lit8     = instr[LIT8_W-1:0];

endmodule

// File: rtl/pc_seq_stack.sv
module pc_seq_stack
    import pc_seq_pkg::*;
#(
    parameter int AW    = DEF_PC_W,
    parameter int PW    = DEF_PG_W,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    input  logic [PW-1:0] push_page,
    output logic [AW-1:0] top_addr,
    output logic [PW-1:0] top_page
);
    localparam int EW = AW + PW;

    logic [EW-1:0] ent [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_ent
            logic [EW-1:0] from_above;
            logic [EW-1:0] from_below;

            if (i == 0) begin : g_head
                assign from_above = {push_addr, push_page};
            end else begin : g_mid_a
                assign from_above = ent[i-1];
            end

            if (i == DEPTH - 1) begin : g_tail
                assign from_below = ent[i];
            end else begin : g_mid_b
                assign from_below = ent[i+1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ent[i] <= '0;
                else if (push)
                    ent[i] <= from_above;
                else if (pop)
                    ent[i] <= from_below;
            end
        end
    endgenerate

    assign top_addr = ent[0][EW-1:PW];
    assign top_page = ent[0][PW-1:0];

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PC_W  = DEF_PC_W,
    parameter int PG_W  = DEF_PG_W,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 skip_req,
    output logic [PC_W-1:0]      fetch_addr,
    output logic                 flush_slot,
    output logic                 w_load,
    output logic [LIT8_W-1:0]    w_literal,
    output logic [PG_W-1:0]      page_bits
);
    seq_state_e        state_q, state_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [PG_W-1:0]   pg_q, pg_d;
    logic              do_push, do_pop, do_wload;

    op_class_e         op;
    logic [PC_W-1:0]   jump_tgt, call_tgt, stk_addr;
    logic [PG_W-1:0]   page_lit, stk_page;
    logic [LIT8_W-1:0] lit8;

    pc_seq_decode #(.PC_W(PC_W), .PG_W(PG_W)) u_dec (
        .instr    (instr),
        .page     (pg_q),
        .op       (op),
        .jump_tgt (jump_tgt),
        .call_tgt (call_tgt),
        .page_lit (page_lit),
        .lit8     (lit8)
    );

    pc_seq_stack #(.AW(PC_W), .PW(PG_W), .DEPTH(DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (pc_q),
        .push_page (pg_q),
        .top_addr  (stk_addr),
        .top_page  (stk_page)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '1;
            pg_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            pg_q    <= pg_d;
        end
    end

    // next state, address, page and stack control
    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        pg_d     = pg_q;
        do_push  = 1'b0;
        do_pop   = 1'b0;
        do_wload = 1'b0;
        if (instr_valid) begin
            pc_d = pc_q + 1'b1;
            unique case (state_q)
                ST_RUN: begin
                    unique case (op)
                        OPC_JUMP: begin
                            pc_d    = jump_tgt;
                            state_d = ST_SLOT_ANNUL;
                        end
                        OPC_CALL: begin
                            do_push = 1'b1;
                            pc_d    = call_tgt;
                            state_d = ST_SLOT_ANNUL;
                        end
                        OPC_RET: begin
                            do_pop  = 1'b1;
                            pc_d    = stk_addr;
                            state_d = ST_SLOT_ANNUL;
                        end
                        OPC_RETL: begin
                            do_pop   = 1'b1;
                            do_wload = 1'b1;
                            pc_d     = stk_addr;
                            state_d  = ST_SLOT_ANNUL;
                        end
                        OPC_RETPG: begin
                            do_pop  = 1'b1;
                            pc_d    = stk_addr;
                            pg_d    = stk_page;
                            state_d = ST_SLOT_ANNUL;
                        end
                        OPC_PAGE: begin
                            pg_d    = page_lit;
                            state_d = skip_req ? ST_SLOT_ANNUL : ST_RUN;
                        end
                        default: begin
                            state_d = skip_req ? ST_SLOT_ANNUL : ST_RUN;
                        end
                    endcase
                end
                ST_SLOT_ANNUL: begin
                    state_d = ST_RUN;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        fetch_addr = pc_q;
        page_bits  = pg_q;
        flush_slot = (state_q == ST_SLOT_ANNUL);
        w_load     = do_wload;
        w_literal  = do_wload ? lit8 : '0;
    end

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int PC_W = 12,
    parameter int PG_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [11:0]     instr,
    input logic            skip_req,
    input logic [PC_W-1:0] fetch_addr,
    input logic            flush_slot,
    input logic            w_load,
    input logic [7:0]      w_literal,
    input logic [PG_W-1:0] page_bits
);
    logic live;
    assign live = instr_valid && !flush_slot;

    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        live && instr[11:9] == 3'b101 |=>
            fetch_addr == {$past(page_bits), $past(instr[8:0])} && flush_slot);

    a_r4_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        live && instr[11:8] == 4'b1001 |=>
            fetch_addr == {$past(page_bits), 1'b0, $past(instr[7:0])} && flush_slot);

    a_r6_wload_literal: assert property (@(posedge clk) disable iff (!rst_n)
        w_load |-> live && instr[11:8] == 4'b1000 && w_literal == instr[7:0]);

    a_r8_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        live && instr[11:3] == 9'b0000_0001_0 |=> page_bits == $past(instr[2:0]));

    a_r9_skip_flush: assert property (@(posedge clk) disable iff (!rst_n)
        live && skip_req |=> flush_slot);

    a_r10_annul_step: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && flush_slot |=>
            fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && !flush_slot && $stable(page_bits));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(fetch_addr) && $stable(page_bits) && $stable(flush_slot));

endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .PG_W(PG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .skip_req    (skip_req),
    .fetch_addr  (fetch_addr),
    .flush_slot  (flush_slot),
    .w_load      (w_load),
    .w_literal   (w_literal),
    .page_bits   (page_bits)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [11:0] instr = '0;
    logic        skip_req = 1'b0;
    logic [11:0] fetch_addr;
    logic        flush_slot;
    logic        w_load;
    logic [7:0]  w_literal;
    logic [2:0]  page_bits;

    int total = 0;
    int bad = 0;
    logic       wl_seen;
    logic [7:0] lit_seen;

    always #2.5 clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .skip_req(skip_req), .fetch_addr(fetch_addr), .flush_slot(flush_slot),
        .w_load(w_load), .w_literal(w_literal), .page_bits(page_bits)
    );

    localparam logic [11:0] NOP = 12'h000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [11:0] ins, input logic sk);
        @(negedge clk);
        instr_valid = v; instr = ins; skip_req = sk;
        #1;
        wl_seen = w_load; lit_seen = w_literal;
        @(posedge clk);
        #1;
        instr_valid = 1'b0; skip_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pc", fetch_addr, 12'hFFF);
        chk("R1 page", page_bits, 3'd0);
        chk("R1 flush", flush_slot, 1'b0);
    endtask

    task automatic t_sequential();
        step(1, NOP, 0);
        chk("R2 wrap", fetch_addr, 12'h000);
        step(1, NOP, 0);
        chk("R2 inc", fetch_addr, 12'h001);
        chk("R2 flush", flush_slot, 1'b0);
    endtask

    task automatic t_page_and_jump();
        step(1, 12'h015, 0);
        chk("R8 page", page_bits, 3'd5);
        chk("R8 pc", fetch_addr, 12'h002);
        step(1, 12'hBA3, 0);
        chk("R3 target", fetch_addr, 12'hBA3);
        chk("R3 flush", flush_slot, 1'b1);
        step(1, 12'h012, 1);
        chk("R10 pc", fetch_addr, 12'hBA4);
        chk("R10 page kept", page_bits, 3'd5);
        chk("R10 flush clear", flush_slot, 1'b0);
    endtask

    task automatic t_skip_and_hold();
        step(1, NOP, 1);
        chk("R9 pc", fetch_addr, 12'hBA5);
        chk("R9 flush", flush_slot, 1'b1);
        step(1, NOP, 0);
        chk("R9 resume", fetch_addr, 12'hBA6);
        step(0, 12'hA00, 1);
        chk("R11 pc", fetch_addr, 12'hBA6);
        chk("R11 flush", flush_slot, 1'b0);
        chk("R11 page", page_bits, 3'd5);
    endtask

    task automatic t_call_return();
        step(1, 12'h945, 0);
        chk("R4 target", fetch_addr, 12'hA45);
        chk("R4 flush", flush_slot, 1'b1);
        step(1, NOP, 0);
        step(1, 12'h011, 0);
        chk("R8 page1", page_bits, 3'd1);
        step(1, 12'h910, 0);
        chk("R4 target pg1", fetch_addr, 12'h210);
        step(1, NOP, 0);
        step(1, 12'h013, 0);
        step(1, 12'h85A, 0);
        chk("R6 wload", wl_seen, 1'b1);
        chk("R6 literal", lit_seen, 8'h5A);
        chk("R6 pc", fetch_addr, 12'hA47);
        chk("R6 page kept", page_bits, 3'd3);
        step(1, 12'h85A, 0);
        chk("R10 no wload", wl_seen, 1'b0);
        chk("R10 pc", fetch_addr, 12'hA48);
        step(1, 12'h00D, 0);
        chk("R7 pc", fetch_addr, 12'hBA6);
        chk("R7 page", page_bits, 3'd5);
        step(1, NOP, 0);
        chk("R7 resume", fetch_addr, 12'hBA7);
    endtask

    task automatic t_stack_depth();
        step(1, 12'h930, 0); step(1, NOP, 0);
        step(1, 12'h940, 0); step(1, NOP, 0);
        step(1, 12'h950, 0); step(1, NOP, 0);
        chk("R4 third call", fetch_addr, 12'hA51);
        step(1, 12'h00C, 0);
        chk("R5 pop1", fetch_addr, 12'hA41);
        chk("R5 no wload", wl_seen, 1'b0);
        chk("R5 page", page_bits, 3'd5);
        step(1, NOP, 0);
        step(1, 12'h00C, 0);
        chk("R12 pop2", fetch_addr, 12'hA31);
        step(1, NOP, 0);
        step(1, 12'h00C, 0);
        chk("R12 pop past bottom", fetch_addr, 12'hA31);
        chk("R5 flush", flush_slot, 1'b1);
    endtask

    initial begin
        #200_000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #12;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_sequential();
        t_page_and_jump();
        t_skip_and_hold();
        t_call_return();
        t_stack_depth();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule